// File: doc/BRIEF.md
# Self-Recovering Watchdog Reset Generator

This block supervises a processor through a periodic service signal. It counts ticks of a slow prescaled timebase. After a power-up start it holds the processor in reset for a short debounce interval plus one timeout period. It then releases reset and waits for the processor to service it through an active-low clear input. If the clear does not arrive in time, reset is asserted. It does not stay latched: each further unserviced timeout flips the reset polarity, so the processor sees a square wave of period twice the timeout. This continues until software recovers and clears the timer.

A supply supervisor upstream drives two controls. One is a run enable, which stops the timer and forces reset as soon as it drops. The other is a power-up start strobe, which begins a fresh power-on sequence. The clear input is asynchronous. It is synchronized and must stay low for a minimum number of system clocks before it is acted on. Reset is presented on two registered pins, one active-high and one active-low.

Top module: `wd_recover`

## Requirements
- R1: While `rst_n` is low, and from the clock after `run_i` is sampled low, `rst_o` = 1 and `rst_n_o` = 0. Ticks, clears and power-up strobes have no effect until `pwrup_i` is sampled high with `run_i` high.
- R2: Sampling `pwrup_i` high with `run_i` high restarts the power-on sequence from any state, with reset active.
- R3: After a power-up start, reset stays active for exactly DBNC + TO_TICKS timebase ticks, where DBNC = TO_TICKS >> 6. It goes inactive on the last of these ticks.
- R4: A clear that arrives during the power-on sequence is ignored. The sequence length is unchanged.
- R5: Once the power-on sequence is complete, with no clear, reset goes active TO_TICKS ticks after release. It then toggles every TO_TICKS ticks, forming a square wave.
- R6: A qualified clear has two effects. It returns the timeout count to zero, so the next activation comes exactly TO_TICKS ticks later. It also forces reset inactive, whichever phase the square wave was in. A clear is qualified when the synchronized `clr_n_i` stays low for MIN_LOW system clocks.
- R7: A low pulse on `clr_n_i` shorter than MIN_LOW clocks is ignored. Both the output and the tick count continue undisturbed.
- R8: Holding `clr_n_i` low yields a single clear. The square wave then continues with period 2×TO_TICKS, and the later rising edge of `clr_n_i` has no effect.
- R9: `rst_n_o` is always the exact complement of `rst_o`. Both are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-clock timebase tick from the prescaler |
| run_i | input | 1 | Supervisor run enable; low forces reset and stops the timer |
| pwrup_i | input | 1 | Supervisor strobe that starts a power-on sequence |
| clr_n_i | input | 1 | Asynchronous active-low timer clear from the processor |
| rst_o | output | 1 | Active-high reset to the processor |
| rst_n_o | output | 1 | Active-low reset to the processor |

## Verification
The bench builds the block with TO_TICKS = 128 and MIN_LOW = 3, which gives a two-tick debounce interval. With these values every phase length can be counted tick by tick, and the exact clear-width threshold can be probed. Clears are swept across the timeout window in both square-wave phases. The remaining tick count before the next toggle is compared with an arithmetic expectation. Pulses of MIN_LOW and MIN_LOW−1 clocks show the qualification boundary.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_DBNC  = 2'd1,
        ST_POR   = 2'd2,
        ST_WATCH = 2'd3
    } wdr_state_e;

    typedef struct packed {
        wdr_state_e st;
        logic       act;
        logic       act_n;
    } wdr_ctl_t;

endpackage

// File: rtl/wdr_clr_qual.sv
module wdr_clr_qual #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_i,
    output logic qual_o
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] QUAL_AT = CW'(MIN_LOW - 1);
    localparam logic [CW-1:0] SAT_AT  = CW'(MIN_LOW);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] low;
    } qual_t;

    qual_t q, d;

    always_comb begin
        d    = q;
        d.s1 = clr_n_i;
        d.s2 = q.s1;
        if (q.s2) begin
            d.low = '0;
        end else if (q.low != SAT_AT) begin
            d.low = q.low + 1'b1;
        end
    end

    // one-cycle strobe when the low phase reaches the minimum width
    assign qual_o = !q.s2 && (q.low == QUAL_AT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1  <= 1'b1;
            q.s2  <= 1'b1;
            q.low <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/wdr_period_cnt.sv
module wdr_period_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign done_o = tick_i && (cnt_q == last_i);

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = done_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/wd_recover.sv
module wd_recover #(
    parameter int TO_TICKS = 100,
    parameter int MIN_LOW  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic pwrup_i,
    input  logic clr_n_i,
    output logic rst_o,
    output logic rst_n_o
);
    import wdr_pkg::*;

    localparam int DBNC  = TO_TICKS >> 6;
    localparam int CNT_W = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
    localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(TO_TICKS - 1);
    localparam logic [CNT_W-1:0] DBNC_LAST = CNT_W'((DBNC > 0) ? DBNC - 1 : 0);
    localparam wdr_state_e START_ST = (DBNC > 0) ? ST_DBNC : ST_POR;

    wdr_ctl_t         q, d;
    logic             qual;
    logic             done;
    logic             restart;
    logic [CNT_W-1:0] last;

    wdr_clr_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n_i (clr_n_i),
        .qual_o  (qual)
    );

    wdr_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (restart),
        .last_i    (last),
        .done_o    (done)
    );

    assign last = (q.st == ST_DBNC) ? DBNC_LAST : TO_LAST;

    always_comb begin
        d       = q;
        restart = 1'b0;
        if (!run_i) begin
            d.st    = ST_OFF;
            d.act   = 1'b1;
            restart = 1'b1;
        end else if (pwrup_i) begin
            d.st    = START_ST;
            d.act   = 1'b1;
            restart = 1'b1;
        end else begin
            unique case (q.st)
                ST_OFF: begin
                    d.act   = 1'b1;
                    restart = 1'b1;
                end
                ST_DBNC: begin
                    if (done) d.st = ST_POR;
                end
                ST_POR: begin
                    if (done) begin
                        d.st  = ST_WATCH;
                        d.act = 1'b0;
                    end
                end
                ST_WATCH: begin
                    if (qual) begin
                        d.act   = 1'b0;
                        restart = 1'b1;
                    end else if (done) begin
                        d.act = ~q.act;
                    end
                end
                default: d.st = ST_OFF;
            endcase
        end
        d.act_n = ~d.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_OFF;
            q.act   <= 1'b1;
            q.act_n <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rst_o   = q.act;
    assign rst_n_o = q.act_n;
endmodule

// File: rtl/wdr_checker.sv
module wdr_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic run_i,
    input logic pwrup_i,
    input logic rst_o,
    input logic rst_n_o
);
    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o == !rst_o);

    a_r1_run_low_forces: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> rst_o);

    a_r2_pwrup_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && pwrup_i) |=> rst_o);

    // R5: reset can only become active on a tick, a run drop or a power-up start
    a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> ($past(tick_i) || !$past(run_i) || $past(pwrup_i)));

    // R6: release only while running and not restarting
    a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> ($past(run_i) && !$past(pwrup_i)));
endmodule

bind wd_recover wdr_checker u_chk (.*);

// File: tb/test_wd_recover.sv
module test_wd_recover;
    localparam int CLK_PERIOD = 10;
    localparam int TO   = 128;
    localparam int MINL = 3;
    localparam int DBNC = TO / 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic run_i = 1'b0;
    logic pwrup_i = 1'b0;
    logic clr_n_i = 1'b1;
    logic rst_o, rst_n_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wd_recover #(.TO_TICKS(TO), .MIN_LOW(MINL)) i_wd_recover (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .pwrup_i(pwrup_i), .clr_n_i(clr_n_i), .rst_o(rst_o), .rst_n_o(rst_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic exp_rst);
        check(req, int'(rst_o), int'(exp_rst));
        check("R9", int'(rst_n_o), int'(!exp_rst));
    endtask

    task automatic tick();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic measure(output int n);
        logic start;
        start = rst_o;
        n = 0;
        while (rst_o == start && n < 4*TO) begin
            tick();
            n++;
        end
    endtask

    task automatic clr_pulse(input int len);
        @(negedge clk) clr_n_i = 1'b0;
        repeat (len) @(negedge clk);
        clr_n_i = 1'b1;
        repeat (MINL + 4) @(negedge clk);
    endtask

    task automatic power_up();
        @(negedge clk) begin run_i = 1'b1; pwrup_i = 1'b1; end
        @(negedge clk) pwrup_i = 1'b0;
    endtask

    initial begin
        repeat (20000 * 10) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check_out("R1", 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: run low, ticks and clears ignored
        ticks(5);
        clr_pulse(MINL + 2);
        check_out("R1", 1'b1);

        // R3: power-on sequence length
        power_up();
        check_out("R2", 1'b1);
        measure(n);
        check("R3", n, DBNC + TO);
        check_out("R3", 1'b0);

        // R5: square wave without clears
        for (int c = 0; c < 3; c++) begin
            measure(n);
            check("R5", n, TO);
        end
        check_out("R5", 1'b1);

        // R2/R4: restart mid-wave, clear inside power-on delay ignored
        ticks(7);
        power_up();
        check_out("R2", 1'b1);
        ticks(DBNC + 5);
        clr_pulse(MINL + 1);
        check_out("R4", 1'b1);
        measure(n);
        check("R4", n + DBNC + 5, DBNC + TO);

        // R6: sweep clear position in both phases
        for (int k = 0; k < TO; k += 16) begin
            ticks(k);
            clr_pulse(MINL);
            check_out("R6", 1'b0);
            measure(n);
            check("R6", n, TO);
            ticks(k);
            clr_pulse(MINL);
            check_out("R6", 1'b0);
            measure(n);
            check("R6", n, TO);
        end

        // R7: glitch one clock below minimum is ignored
        ticks(10);
        clr_pulse(MINL - 1);
        check_out("R7", 1'b1);
        measure(n);
        check("R7", n, TO - 10);

        // R8: clear held low gives one clear, wave continues
        ticks(20);
        @(negedge clk) clr_n_i = 1'b0;
        repeat (MINL + 4) @(negedge clk);
        check_out("R8", 1'b0);
        measure(n);
        check("R8", n, TO);
        measure(n);
        check("R8", n, TO);
        @(negedge clk) clr_n_i = 1'b1;
        repeat (MINL + 4) @(negedge clk);
        check_out("R8", 1'b0);
        measure(n);
        check("R8", n, TO);

        // R1: run drop forces reset immediately, clears then ignored
        ticks(3);
        clr_pulse(MINL);
        check_out("R6", 1'b0);
        @(negedge clk) run_i = 1'b0;
        @(negedge clk);
        check_out("R1", 1'b1);
        @(negedge clk) run_i = 1'b1;
        clr_pulse(MINL + 2);
        ticks(TO + 4);
        check_out("R1", 1'b1);
        power_up();
        measure(n);
        check("R3", n, DBNC + TO);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule